// File: doc/BRIEF.md
# Virtual Timer Control Access Decoder

This block settles what happens when software issues a system-register read or write aimed at the virtual timer's control register. It looks at the requesting privilege level, at which of the two instruction aliases was used, and at a handful of hypervisor and secure-state configuration bits. From these it produces exactly one verdict. The access may be performed on the primary register, or sent to one of two hypervisor-owned alternate registers (one secure, one non-secure). It may be redirected to a fixed offset in the nested-virtualisation memory page. It may trap to level 1 or level 2 with an exception class, or it may be refused as an undefined instruction.

The decoder is purely combinational and holds no register state. The pipeline stage that owns the system-register instruction drives the inputs and uses the one-hot verdict, the trap target, the exception class and the memory offset in the same cycle. The decision is a prioritised tree. Host mode is derived inside the block from the level-2 enable, the host-extension bit and the trap-general bit. The nested-virtualisation field counts only while level 2 is enabled.

Top module: `tvc_access_decoder`

## Requirements
- R1: `verdict_o` is one-hot for every input combination. Bit 0 means the primary register, bit 1 the secure alternate register, bit 2 the non-secure alternate register, bit 3 the memory offset, bit 4 a trap, and bit 5 an undefined instruction.
- R2: A trap drives `ec_o` to 0x18 and `trap_lvl_o` to 1 or 2. In every other case both outputs are 0. `ofs_o` is 0x170 for a memory verdict and 0 otherwise.
- R3: User-level host mode is `lvl2_en_i & host_ext_i & trap_gen_i`. Level-2 host mode is `lvl2_en_i & host_ext_i`. The effective nested field is `nest_i` when `lvl2_en_i` is 1 and 0b000 otherwise.
- R4: With the primary alias at level 0, outside user-level host mode and with `usr_en_k_i` clear, the access traps. The target is level 2 when `lvl2_en_i & trap_gen_i`, and level 1 otherwise.
- R5: With the primary alias at level 0, the access traps to level 2 in either of two cases. The first is user-level host mode with `usr_en_h_i` clear. The second is outside host mode with `usr_en_k_i` set, `lvl2_en_i` set and `l1_tmr_trap_i` set.
- R6: With the primary alias, a level-0 access in user-level host mode that is not trapped by R5 is redirected, and so is a level-2 access in level-2 host mode. The target is the secure alternate register when `ns_i` is 0 and `sec_l2_i` is 1, and the non-secure alternate register when `ns_i` is 1. Otherwise the primary register is accessed, and that is also the result at level 2 outside host mode.
- R7: With the primary alias at level 1, `lvl2_en_i & l1_tmr_trap_i` traps to level 2. Otherwise an effective nested field of 0b111 selects the memory verdict, and any other value selects the primary register.
- R8: With the primary alias at level 3, the verdict is always the primary register.
- R9: With the second alias, level 0 always gives an undefined instruction. At levels 2 and 3 the second alias gives the primary register in level-2 host mode and an undefined instruction otherwise.
- R10: With the second alias at level 1 and an effective nested field of 0b101, the access traps to level 2 when `lvl2_en_i`, `nv_tmr_trap_i` are set and user-level host mode is off. Otherwise it takes the memory verdict. Any other effective field with bit 0 set traps to level 2, and the remaining values give an undefined instruction.
- R11: `wr_i` has no effect on `verdict_o`, `trap_lvl_o`, `ec_o` or `ofs_o`. `wr_o` equals `wr_i` when the verdict is an access (bits 0 to 3) and is 0 for traps and undefined instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lvl_i | input | 2 | Current privilege level, 0 to 3 |
| wr_i | input | 1 | 1 for a register write, 0 for a read |
| alias2_i | input | 1 | 0: primary alias (op1=0b011); 1: second alias (op1=0b101) |
| lvl2_en_i | input | 1 | Level 2 is enabled in the current security state |
| host_ext_i | input | 1 | Host-extension bit of the hypervisor configuration |
| trap_gen_i | input | 1 | Trap-general bit of the hypervisor configuration |
| usr_en_k_i | input | 1 | Kernel-owned enable for level-0 access to the virtual timer |
| usr_en_h_i | input | 1 | Hypervisor-owned enable for level-0 access in host mode |
| l1_tmr_trap_i | input | 1 | Hypervisor bit trapping level-1 virtual timer access |
| nv_tmr_trap_i | input | 1 | Hypervisor bit trapping nested virtual timer access |
| nest_i | input | 3 | Nested-virtualisation control field |
| ns_i | input | 1 | Non-secure state |
| sec_l2_i | input | 1 | Secure level 2 is implemented |
| verdict_o | output | 6 | One-hot verdict (see R1) |
| trap_lvl_o | output | 2 | Trap target level, 0 when not trapping |
| ec_o | output | 6 | Exception class, 0x18 on a trap, else 0 |
| ofs_o | output | 12 | Memory-page offset, 0x170 on a memory verdict, else 0 |
| wr_o | output | 1 | Write qualifier for a performed access |

## Verification
Every result of this block is combinational, so the verdict, the trap target, the class, the offset and the write qualifier are all due in the cycle the inputs change, with no register on the path. The bench changes the inputs on the falling clock edge and samples the outputs one time unit after the following rising edge. This leaves half a period for the logic to settle and keeps sampling away from any edge at which the stimulus moves. The sweep covers all 65536 input combinations, with the write flag as the fastest bit, so that each read result can be compared with the matching write result one step later.

// File: rtl/tvc_pkg.sv
// Package: shared types and constants for the virtual timer control access
// decoder. Assumes the verdict kinds are listed in one-hot bit order.
package tvc_pkg;

    localparam int KIND_N   = 6;
    localparam int LVL_W    = 2;
    localparam int NEST_W   = 3;
    localparam int EC_W     = 6;
    localparam int OFS_W    = 12;
    localparam logic [EC_W-1:0]  EC_TIMER  = 6'h18;
    localparam logic [OFS_W-1:0] NEST_OFS  = 12'h170;

    // Verdict kinds; the numeric value is the one-hot bit position.
    typedef enum logic [2:0] {
        K_PRIMARY = 3'd0,
        K_ALT_SEC = 3'd1,
        K_ALT_NS  = 3'd2,
        K_MEM     = 3'd3,
        K_TRAP    = 3'd4,
        K_UNDEF   = 3'd5
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [LVL_W-1:0]  tgt;
    } verdict_t;

    // Chooses the register a host-mode access lands on.
    function automatic kind_e host_redirect(input logic ns, input logic sec_l2);
        if (!ns && sec_l2) return K_ALT_SEC;
        else if (ns)       return K_ALT_NS;
        else               return K_PRIMARY;
    endfunction

endpackage

// File: rtl/tvc_host_resolve.sv
// Module: derives the host-mode flags and the effective nested field from
// the raw configuration bits. Assumes the bits are stable within a cycle.
module tvc_host_resolve
    import tvc_pkg::*;
#(
    parameter int NW = NEST_W
) (
    input  logic          lvl2_en_i,
    input  logic          host_ext_i,
    input  logic          trap_gen_i,
    input  logic [NW-1:0] nest_i,
    output logic          host_usr_o,
    output logic          host_l2_o,
    output logic [NW-1:0] nest_eff_o
);

    // Host-mode flags for level 0 and level 2.
    always_comb begin
        host_l2_o  = lvl2_en_i & host_ext_i;
        host_usr_o = lvl2_en_i & host_ext_i & trap_gen_i;
    end

    // The nested field only counts while level 2 is enabled.
    always_comb begin
        nest_eff_o = lvl2_en_i ? nest_i : '0;
    end

    // R3: level-0 host mode implies level-2 host mode.
    always_comb begin
        assert_host_nest_R3: assert (!host_usr_o || host_l2_o)
            else $error("host flags inconsistent");
    end

endmodule

// File: rtl/tvc_primary_path.sv
// Module: decision tree for the primary alias (op1=0b011). Assumes host
// flags and the effective nested field come from tvc_host_resolve.
module tvc_primary_path
    import tvc_pkg::*;
#(
    parameter int NW = NEST_W
) (
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             lvl2_en_i,
    input  logic             trap_gen_i,
    input  logic             host_usr_i,
    input  logic             host_l2_i,
    input  logic             usr_en_k_i,
    input  logic             usr_en_h_i,
    input  logic             l1_tmr_trap_i,
    input  logic [NW-1:0]    nest_eff_i,
    input  logic             ns_i,
    input  logic             sec_l2_i,
    output verdict_t         v_o
);

    // Prioritised tree per privilege level.
    always_comb begin
        v_o.kind = K_PRIMARY;
        v_o.tgt  = '0;
        unique case (lvl_i)
            2'd0: begin
                if (!host_usr_i && !usr_en_k_i) begin
                    v_o.kind = K_TRAP;
                    v_o.tgt  = (lvl2_en_i && trap_gen_i) ? 2'd2 : 2'd1;
                end else if (host_usr_i && !usr_en_h_i) begin
                    v_o.kind = K_TRAP;
                    v_o.tgt  = 2'd2;
                end else if (lvl2_en_i && !host_usr_i && l1_tmr_trap_i) begin
                    v_o.kind = K_TRAP;
                    v_o.tgt  = 2'd2;
                end else if (host_usr_i) begin
                    v_o.kind = host_redirect(ns_i, sec_l2_i);
                end
            end
            2'd1: begin
                if (lvl2_en_i && l1_tmr_trap_i) begin
                    v_o.kind = K_TRAP;
                    v_o.tgt  = 2'd2;
                end else if (nest_eff_i == NW'(3'b111)) begin
                    v_o.kind = K_MEM;
                end
            end
            2'd2: begin
                if (host_l2_i) v_o.kind = host_redirect(ns_i, sec_l2_i);
            end
            default: ;
        endcase
    end

    // R8: level 3 on the primary alias reaches the primary register.
    always_comb begin
        assert_lvl3_direct_R8: assert (lvl_i != 2'd3 || v_o.kind == K_PRIMARY)
            else $error("level 3 primary alias not direct");
    end

endmodule

// File: rtl/tvc_alt_path.sv
// Module: decision tree for the second alias (op1=0b101). Assumes host
// flags and the effective nested field come from tvc_host_resolve.
module tvc_alt_path
    import tvc_pkg::*;
#(
    parameter int NW = NEST_W
) (
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             lvl2_en_i,
    input  logic             host_usr_i,
    input  logic             host_l2_i,
    input  logic             nv_tmr_trap_i,
    input  logic [NW-1:0]    nest_eff_i,
    output verdict_t         v_o
);

    // Prioritised tree per privilege level.
    always_comb begin
        v_o.kind = K_UNDEF;
        v_o.tgt  = '0;
        unique case (lvl_i)
            2'd0: v_o.kind = K_UNDEF;
            2'd1: begin
                if (nest_eff_i == NW'(3'b101)) begin
                    if (lvl2_en_i && !host_usr_i && nv_tmr_trap_i) begin
                        v_o.kind = K_TRAP;
                        v_o.tgt  = 2'd2;
                    end else begin
                        v_o.kind = K_MEM;
                    end
                end else if (nest_eff_i[0]) begin
                    v_o.kind = K_TRAP;
                    v_o.tgt  = 2'd2;
                end
            end
            default: v_o.kind = host_l2_i ? K_PRIMARY : K_UNDEF;
        endcase
    end

    // R9: the second alias is never usable at level 0.
    always_comb begin
        assert_lvl0_undef_R9: assert (lvl_i != 2'd0 || v_o.kind == K_UNDEF)
            else $error("second alias at level 0 not undefined");
    end

endmodule

// File: rtl/tvc_access_decoder.sv
// Module: top of the virtual timer control access decoder. Selects the
// verdict of the alias in use and encodes it onto one-hot and side outputs.
// Assumes a purely combinational use; no clock or reset is needed.
module tvc_access_decoder
    import tvc_pkg::*;
#(
    parameter int                NW      = NEST_W,
    parameter int                ECW     = EC_W,
    parameter int                OW      = OFS_W,
    parameter logic [ECW-1:0]    EC_VAL  = EC_TIMER,
    parameter logic [OW-1:0]     OFS_VAL = NEST_OFS
) (
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic              wr_i,
    input  logic              alias2_i,
    input  logic              lvl2_en_i,
    input  logic              host_ext_i,
    input  logic              trap_gen_i,
    input  logic              usr_en_k_i,
    input  logic              usr_en_h_i,
    input  logic              l1_tmr_trap_i,
    input  logic              nv_tmr_trap_i,
    input  logic [NW-1:0]     nest_i,
    input  logic              ns_i,
    input  logic              sec_l2_i,
    output logic [KIND_N-1:0] verdict_o,
    output logic [LVL_W-1:0]  trap_lvl_o,
    output logic [ECW-1:0]    ec_o,
    output logic [OW-1:0]     ofs_o,
    output logic              wr_o
);

    logic          host_usr;
    logic          host_l2;
    logic [NW-1:0] nest_eff;
    verdict_t      v_pri;
    verdict_t      v_alt;
    verdict_t      v_sel;

    tvc_host_resolve #(.NW(NW)) u_host (
        .lvl2_en_i  (lvl2_en_i),
        .host_ext_i (host_ext_i),
        .trap_gen_i (trap_gen_i),
        .nest_i     (nest_i),
        .host_usr_o (host_usr),
        .host_l2_o  (host_l2),
        .nest_eff_o (nest_eff)
    );

    tvc_primary_path #(.NW(NW)) u_pri (
        .lvl_i         (lvl_i),
        .lvl2_en_i     (lvl2_en_i),
        .trap_gen_i    (trap_gen_i),
        .host_usr_i    (host_usr),
        .host_l2_i     (host_l2),
        .usr_en_k_i    (usr_en_k_i),
        .usr_en_h_i    (usr_en_h_i),
        .l1_tmr_trap_i (l1_tmr_trap_i),
        .nest_eff_i    (nest_eff),
        .ns_i          (ns_i),
        .sec_l2_i      (sec_l2_i),
        .v_o           (v_pri)
    );

    tvc_alt_path #(.NW(NW)) u_alt (
        .lvl_i         (lvl_i),
        .lvl2_en_i     (lvl2_en_i),
        .host_usr_i    (host_usr),
        .host_l2_i     (host_l2),
        .nv_tmr_trap_i (nv_tmr_trap_i),
        .nest_eff_i    (nest_eff),
        .v_o           (v_alt)
    );

    // Pick the verdict of the alias in use.
    always_comb begin
        v_sel = alias2_i ? v_alt : v_pri;
    end

    // One-hot verdict, one bit per kind.
    for (genvar g = 0; g < KIND_N; g++) begin : g_onehot
        assign verdict_o[g] = (v_sel.kind == kind_e'(g));
    end

    // Side outputs are driven only for their own verdict kind.
    always_comb begin
        trap_lvl_o = (v_sel.kind == K_TRAP) ? v_sel.tgt : '0;
        ec_o       = (v_sel.kind == K_TRAP) ? EC_VAL : '0;
        ofs_o      = (v_sel.kind == K_MEM)  ? OFS_VAL : '0;
        wr_o       = wr_i & (|verdict_o[3:0]);
    end

    // Output-level checks guarding the encoder.
    always_comb begin
        assert_onehot_R1: assert ($onehot(verdict_o))
            else $error("verdict not one-hot");
        assert_trap_fields_R2: assert (verdict_o[4] ?
                ((trap_lvl_o == 2'd1 || trap_lvl_o == 2'd2) && ec_o == EC_VAL) :
                (trap_lvl_o == '0 && ec_o == '0))
            else $error("trap side outputs wrong");
        assert_ofs_R2: assert (verdict_o[3] ? (ofs_o == OFS_VAL) : (ofs_o == '0))
            else $error("offset output wrong");
        assert_wr_gate_R11: assert (!wr_o || (wr_i && !verdict_o[4] && !verdict_o[5]))
            else $error("write qualifier on non-access");
    end

endmodule

// File: tb/tb_tvc_access_decoder.sv
module tb_tvc_access_decoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [1:0]  lvl;
    logic        wr, a2, l2en, hext, tgen, uk, uh, l1t, nvt, ns, sl2;
    logic [2:0]  nest;
    logic [5:0]  verdict;
    logic [1:0]  tlvl;
    logic [5:0]  ec;
    logic [11:0] ofs;
    logic        wro;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    tvc_access_decoder dut (
        .lvl_i(lvl), .wr_i(wr), .alias2_i(a2), .lvl2_en_i(l2en),
        .host_ext_i(hext), .trap_gen_i(tgen), .usr_en_k_i(uk),
        .usr_en_h_i(uh), .l1_tmr_trap_i(l1t), .nv_tmr_trap_i(nvt),
        .nest_i(nest), .ns_i(ns), .sec_l2_i(sl2),
        .verdict_o(verdict), .trap_lvl_o(tlvl), .ec_o(ec), .ofs_o(ofs),
        .wr_o(wro)
    );

    localparam logic [5:0] P = 6'b000001, AS = 6'b000010, AN = 6'b000100,
                           M = 6'b001000, T = 6'b010000, U = 6'b100000;

    // Reference model from the requirements; tag names the deciding rule.
    function automatic void model(output logic [5:0] oc, output logic [1:0] tl,
                                  output string tag);
        logic hu, hh;
        logic [2:0] ne;
        hu = l2en & hext & tgen;   // R3
        hh = l2en & hext;          // R3
        ne = l2en ? nest : 3'b000; // R3
        tl = 2'd0;
        oc = P;
        tag = "R8";
        if (!a2) begin
            if (lvl == 2'd0) begin
                if (!hu && !uk) begin oc = T; tl = (l2en && tgen) ? 2'd2 : 2'd1; tag = "R4"; end
                else if (hu && !uh) begin oc = T; tl = 2'd2; tag = "R5"; end
                else if (l2en && !hu && l1t) begin oc = T; tl = 2'd2; tag = "R5"; end
                else if (hu) begin
                    oc = (!ns && sl2) ? AS : (ns ? AN : P); tag = "R6";
                end else tag = "R6";
            end else if (lvl == 2'd1) begin
                tag = "R7";
                if (l2en && l1t) begin oc = T; tl = 2'd2; end
                else if (ne == 3'b111) oc = M;
            end else if (lvl == 2'd2) begin
                tag = "R6";
                if (hh) oc = (!ns && sl2) ? AS : (ns ? AN : P);
            end
        end else begin
            if (lvl == 2'd0) begin oc = U; tag = "R9"; end
            else if (lvl == 2'd1) begin
                tag = "R10";
                if (ne == 3'b101) begin
                    if (l2en && !hu && nvt) begin oc = T; tl = 2'd2; end
                    else oc = M;
                end else if (ne[0]) begin oc = T; tl = 2'd2; end
                else oc = U;
            end else begin
                tag = "R9";
                oc = hh ? P : U;
            end
        end
    endfunction

    task automatic drive(input logic [15:0] s);
        wr = s[0]; a2 = s[1]; lvl = s[3:2]; l2en = s[4]; hext = s[5];
        tgen = s[6]; uk = s[7]; uh = s[8]; l1t = s[9]; nvt = s[10];
        nest = s[13:11]; ns = s[14]; sl2 = s[15];
    endtask

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Watchdog: an overlong run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0]  eoc;
        logic [1:0]  etl;
        string       tag;
        logic [25:0] rd_res;
        logic [25:0] res;
        drive(16'h0000);
        repeat (3) @(posedge clk);
        #1;
        // Reset state: all-zero inputs, level 0, no user enable -> trap to 1 (R4).
        check(verdict == T && tlvl == 2'd1 && ec == 6'h18, "R4",
              {24'd0, verdict, tlvl}, {24'd0, T, 2'd1});
        @(negedge clk);
        rst_n = 1'b1;
        rd_res = '0;
        for (int i = 0; i < 65536; i++) begin
            @(negedge clk);
            drive(i[15:0]);
            @(posedge clk);
            #1;
            model(eoc, etl, tag);
            res = {verdict, tlvl, ec, ofs};
            // R1: exactly one verdict bit.
            check($onehot(verdict), "R1", {26'd0, verdict}, {26'd0, eoc});
            // Verdict and trap level per deciding rule (R4..R10).
            check(verdict == eoc && tlvl == etl, tag,
                  {24'd0, verdict, tlvl}, {24'd0, eoc, etl});
            // R2: class and offset side outputs.
            check(ec == (eoc == T ? 6'h18 : 6'h00) && ofs == (eoc == M ? 12'h170 : 12'h000),
                  "R2", {14'd0, ec, ofs},
                  {14'd0, (eoc == T ? 6'h18 : 6'h00), (eoc == M ? 12'h170 : 12'h000)});
            // R11: write qualifier and independence from the write flag.
            check(wro == (wr & (|eoc[3:0])), "R11", {31'd0, wro}, {31'd0, wr & (|eoc[3:0])});
            if (wr == 1'b0) rd_res = res;
            else check(res == rd_res, "R11", {6'd0, res}, {6'd0, rd_res});
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule